// File: doc/BRIEF.md
# Streaming Multi-Pattern Byte Matcher

This block scans a byte stream for a fixed set of byte strings. It takes at most one byte per clock cycle and reports every string from the set that ends on that byte. The string set is fixed when the design is built. Internally it runs a prefix-tree automaton. The state is the longest tail of the bytes seen so far that is also the start of some string in the set.

Fallback after a mismatch is resolved inside the next-state logic. Each accepted byte therefore costs exactly one transition, and the block never stalls. When the stream is idle, the automaton state is kept. A start-of-packet flag makes the automaton forget everything seen earlier, so a match cannot cross a packet boundary.

The result for a byte is registered and appears one cycle after that byte is accepted. It carries one flag bit per string.

Top module: `ac_byte_matcher`

## Requirements
- R1: An active-low asynchronous reset clears matchValid and matchHits at once. It also returns the automaton to the empty state, so that after reset no earlier byte contributes to a match.
- R2: Each cycle with inValid high yields matchValid high in the following cycle. Bytes may arrive in consecutive cycles with no stall. A cycle with inValid low yields matchValid low in the following cycle.
- R3: matchHits bit i is set in the result cycle of a byte exactly when string i ends on that byte. With the default set, bit 0 is "he", bit 1 is "she", bit 2 is "his" and bit 3 is "her".
- R4: Every string that ends on the same byte is flagged in the same result. For example, the byte "e" of "she" sets bits 0 and 1 together.
- R5: After a mismatch, matching continues from the longest tail of the input that is a prefix of some string. For example, "hhe" flags "he", "shis" flags "his", and "sher" flags "her" on its last byte.
- R6: While inValid is low, the automaton state holds, and the byte and flag inputs are ignored. For example, "s", "h", an idle cycle, then "e" still flags "she" and "he".
- R7: When inSop and inValid are both high, the automaton restarts from the empty state before that byte, and the byte itself is still scanned. For example, "h" followed by a start-of-packet "e" flags nothing, while a start-of-packet "h" followed by "e" flags "he".
- R8: Bytes are compared as exact 8-bit values, so case matters: "hE" and "He" flag nothing.
- R9: matchHits is all zeros in every cycle in which matchValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Byte on inByte is accepted this cycle |
| inSop | input | 1 | Accepted byte is the first of a packet |
| inByte | input | 8 | Payload byte |
| matchValid | output | 1 | A result for the byte accepted in the previous cycle is present |
| matchHits | output | NUM_PAT (4) | One flag per string that ended on that byte |

## Verification
The bench builds the block with the package defaults: four strings, a maximum length of three, and a mix of two- and three-byte strings. This set brings several cases within reach. "he" and "her" share a prefix, so a match can be extended. "he" is a tail of "she", so one byte must flag two strings at once. The "s" left over from "his" and "hers" restarts "she", so fallback past a completed string can be observed. A three-byte maximum keeps every fallback path short enough to be driven exhaustively from a small table.

// File: rtl/acm_pkg.sv
package acm_pkg;

  // string set geometry
  localparam int NUM_PAT = 4;
  localparam int MAX_LEN = 3;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int PAT_W   = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
  localparam int DEP_W   = LEN_W;
  localparam int BYTES_W = NUM_PAT * MAX_LEN * 8;

  // byte j of string i sits at bits [(i*MAX_LEN+j)*8 +: 8]
  // string 0 "he", 1 "she", 2 "his", 3 "her"
  localparam logic [BYTES_W-1:0] PAT_BYTES = {
    8'h72, 8'h65, 8'h68,
    8'h73, 8'h69, 8'h68,
    8'h65, 8'h68, 8'h73,
    8'h00, 8'h65, 8'h68
  };
  localparam logic [NUM_PAT*LEN_W-1:0] PAT_LENS = {2'd3, 2'd3, 2'd3, 2'd2};

  // automaton state: the matched text equals the first depth bytes of string pat
  typedef struct packed {
    logic [PAT_W-1:0] pat;
    logic [DEP_W-1:0] depth;
  } acmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic take;
    logic restart;
  } acmStrobe_t;

  function automatic logic [7:0] patChar(int p, int j);
    return PAT_BYTES[(p * MAX_LEN + j) * 8 +: 8];
  endfunction

  function automatic int patLen(int p);
    return int'(PAT_LENS[p * LEN_W +: LEN_W]);
  endfunction

  // Does the text (first d bytes of string cur, then byte b) end with the
  // first k bytes of string q?
  function automatic logic tailFits(int cur, int d, logic [7:0] b, int q, int k);
    logic ok;
    ok = (k >= 1) && (k <= d + 1) && (k <= patLen(q));
    for (int i = 0; i < MAX_LEN; i++) begin
      if (ok && (i < k)) begin
        int pos;
        logic [7:0] ch;
        pos = d + 1 - k + i;
        ch  = (pos < d) ? patChar(cur, pos) : b;
        if (ch != patChar(q, i)) ok = 1'b0;
      end
    end
    return ok;
  endfunction

endpackage

// File: rtl/acm_ctrl.sv
module acm_ctrl
  import acm_pkg::*;
(
  input  logic       inValid,
  input  logic       inSop,
  output acmStrobe_t strobe
);

  always_comb begin
    strobe.take    = inValid;
    strobe.restart = inValid & inSop;
  end

endmodule

// File: rtl/acm_next.sv
module acm_next
  import acm_pkg::*;
(
  input  acmState_t          curState,
  input  acmStrobe_t         strobe,
  input  logic [7:0]         inByte,
  output acmState_t          nextState,
  output logic [NUM_PAT-1:0] hitNext
);

  always_comb begin : nextLogic
    int basePat;
    int baseDepth;
    int bestPat;
    int bestDepth;

    basePat   = strobe.restart ? 0 : int'(curState.pat);
    baseDepth = strobe.restart ? 0 : int'(curState.depth);

    // longest tail that is a prefix of any string; lowest index wins a tie
    bestPat   = 0;
    bestDepth = 0;
    for (int k = 1; k <= MAX_LEN; k++) begin
      for (int q = 0; q < NUM_PAT; q++) begin
        if ((k > bestDepth) && tailFits(basePat, baseDepth, inByte, q, k)) begin
          bestPat   = q;
          bestDepth = k;
        end
      end
    end

    // every string ending on this byte
    for (int r = 0; r < NUM_PAT; r++) begin
      hitNext[r] = tailFits(basePat, baseDepth, inByte, r, patLen(r));
    end

    nextState.pat   = PAT_W'(bestPat);
    nextState.depth = DEP_W'(bestDepth);

    if (!strobe.take) begin
      nextState = curState;
      hitNext   = '0;
    end
  end

endmodule

// File: rtl/acm_state.sv
module acm_state
  import acm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               take,
  input  acmState_t          nextState,
  input  logic [NUM_PAT-1:0] hitNext,
  output acmState_t          curState,
  output logic               matchValid,
  output logic [NUM_PAT-1:0] matchHits
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= '0;
      matchValid <= 1'b0;
      matchHits  <= '0;
    end else begin
      curState   <= nextState;
      matchValid <= take;
      matchHits  <= hitNext;
    end
  end

endmodule

// File: rtl/ac_byte_matcher.sv
module ac_byte_matcher
  import acm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inSop,
  input  logic [7:0]         inByte,
  output logic               matchValid,
  output logic [NUM_PAT-1:0] matchHits
);

  acmStrobe_t         strobe;
  acmState_t          curState;
  acmState_t          nextState;
  logic [NUM_PAT-1:0] hitNext;

  acm_ctrl u_ctrl (
    .inValid (inValid),
    .inSop   (inSop),
    .strobe  (strobe)
  );

  acm_next u_next (
    .curState  (curState),
    .strobe    (strobe),
    .inByte    (inByte),
    .nextState (nextState),
    .hitNext   (hitNext)
  );

  acm_state u_state (
    .clk        (clk),
    .rstN       (rstN),
    .take       (strobe.take),
    .nextState  (nextState),
    .hitNext    (hitNext),
    .curState   (curState),
    .matchValid (matchValid),
    .matchHits  (matchHits)
  );

endmodule

// File: rtl/acm_checker.sv
module acm_checker
  import acm_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inSop,
  input logic               matchValid,
  input logic [NUM_PAT-1:0] matchHits,
  input acmState_t          stateQ
);

  // string 'inner' is a tail of string 'outer'
  function automatic logic endsWith(int outer, int inner);
    int lo;
    int li;
    lo = patLen(outer);
    li = patLen(inner);
    if (li > lo) return 1'b0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if ((i < li) && (patChar(outer, lo - li + i) != patChar(inner, i))) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [NUM_PAT-1:0] shortMask();
    logic [NUM_PAT-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_PAT; i++) if (patLen(i) == 1) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_PAT-1:0] SHORT_MASK = shortMask();

  p_take_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> matchValid);

  p_idle_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !matchValid);

  p_quiet_hits_r9: assert property (@(posedge clk) disable iff (!rstN)
    !matchValid |-> (matchHits == '0));

  p_hold_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(stateQ));

  p_sop_fresh_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSop) |=> ((matchHits & ~SHORT_MASK) == '0));

  for (genvar gi = 0; gi < NUM_PAT; gi++) begin : g_outer
    for (genvar gj = 0; gj < NUM_PAT; gj++) begin : g_inner
      if ((gi != gj) && endsWith(gi, gj)) begin : g_nest
        p_nested_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
          matchHits[gi] |-> matchHits[gj]);
      end
    end
  end

endmodule

bind ac_byte_matcher acm_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inSop      (inSop),
  .matchValid (matchValid),
  .matchHits  (matchHits),
  .stateQ     (curState)
);

// File: tb/ac_byte_matcher_test.sv
`timescale 1ns/1ps
module ac_byte_matcher_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inSop = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       matchValid;
  logic [3:0] matchHits;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ac_byte_matcher uut (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inSop      (inSop),
    .inByte     (inByte),
    .matchValid (matchValid),
    .matchHits  (matchHits)
  );

  // {valid, sop, byte, expValid, expHits}; hits bit0 he, bit1 she, bit2 his, bit3 her
  localparam int NV = 24;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h75, 1'b1, 4'b0000}, // 'u' sop           R7
    {1'b1, 1'b0, 8'h73, 1'b1, 4'b0000}, // 's'               R3
    {1'b1, 1'b0, 8'h68, 1'b1, 4'b0000}, // 'h'               R3
    {1'b1, 1'b0, 8'h65, 1'b1, 4'b0011}, // 'e' she+he        R4
    {1'b1, 1'b0, 8'h72, 1'b1, 4'b1000}, // 'r' her           R5
    {1'b1, 1'b0, 8'h73, 1'b1, 4'b0000}, // 's'               R5
    {1'b1, 1'b0, 8'h68, 1'b1, 4'b0000}, // 'h'               R5
    {1'b1, 1'b0, 8'h69, 1'b1, 4'b0000}, // 'i'               R5
    {1'b1, 1'b0, 8'h73, 1'b1, 4'b0100}, // 's' his           R5
    {1'b0, 1'b1, 8'h65, 1'b0, 4'b0000}, // idle              R2 R9
    {1'b1, 1'b0, 8'h68, 1'b1, 4'b0000}, // 'h' ("sh")        R6
    {1'b0, 1'b0, 8'h78, 1'b0, 4'b0000}, // idle              R6
    {1'b1, 1'b0, 8'h65, 1'b1, 4'b0011}, // 'e' she+he        R6
    {1'b1, 1'b0, 8'h68, 1'b1, 4'b0000}, // 'h'               R7
    {1'b1, 1'b1, 8'h65, 1'b1, 4'b0000}, // 'e' sop, no hit   R7
    {1'b1, 1'b0, 8'h68, 1'b1, 4'b0000}, // 'h'               R8
    {1'b1, 1'b0, 8'h45, 1'b1, 4'b0000}, // 'E'               R8
    {1'b1, 1'b0, 8'h48, 1'b1, 4'b0000}, // 'H'               R8
    {1'b1, 1'b0, 8'h65, 1'b1, 4'b0000}, // 'e'               R8
    {1'b1, 1'b0, 8'h68, 1'b1, 4'b0000}, // 'h'               R5
    {1'b1, 1'b0, 8'h68, 1'b1, 4'b0000}, // 'h'               R5
    {1'b1, 1'b0, 8'h65, 1'b1, 4'b0001}, // 'e' he            R5
    {1'b1, 1'b1, 8'h68, 1'b1, 4'b0000}, // 'h' sop           R7
    {1'b1, 1'b0, 8'h65, 1'b1, 4'b0001}  // 'e' he            R7
  };

  task automatic compare(input string req, input logic ev, input logic [3:0] eh);
    total++;
    if ((matchValid !== ev) || (matchHits !== eh)) begin
      bad++;
      $display("FAIL %s: valid=%0b hits=%b expected valid=%0b hits=%b",
               req, matchValid, matchHits, ev, eh);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] b);
    @(negedge clk);
    inValid = v;
    inSop   = s;
    inByte  = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL R2: watchdog expired, actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: outputs cleared while in reset
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset outputs", 1'b0, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12:5]);
      compare($sformatf("R3 vector %0d", i), VEC[i][4], VEC[i][3:0]);
    end

    // R1: reset in mid-stream after "h" clears partial progress
    step(1'b1, 1'b0, 8'h68);
    compare("R1 prefix before reset", 1'b1, 4'b0000);
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    #1;
    compare("R1 async clear", 1'b0, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b1, 1'b0, 8'h65);
    compare("R1 no carry over reset", 1'b1, 4'b0000);

    // R2: back-to-back "hehe" then idle
    step(1'b1, 1'b1, 8'h68);
    compare("R2 stream h", 1'b1, 4'b0000);
    step(1'b1, 1'b0, 8'h65);
    compare("R2 stream e", 1'b1, 4'b0001);
    step(1'b1, 1'b0, 8'h68);
    compare("R2 stream h again", 1'b1, 4'b0000);
    step(1'b1, 1'b0, 8'h65);
    compare("R2 stream e again", 1'b1, 4'b0001);
    step(1'b0, 1'b0, 8'h65);
    compare("R9 idle after stream", 1'b0, 4'b0000);

    // R6: idle with sop raised does not restart; "he" then idle sop then "r"
    step(1'b1, 1'b0, 8'h68);
    compare("R6 h", 1'b1, 4'b0000);
    step(1'b1, 1'b0, 8'h65);
    compare("R6 e", 1'b1, 4'b0001);
    step(1'b0, 1'b1, 8'h00);
    compare("R6 idle sop ignored", 1'b0, 4'b0000);
    step(1'b1, 1'b0, 8'h72);
    compare("R6 her after idle", 1'b1, 4'b1000);

    step(1'b0, 1'b0, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule